// File: doc/BRIEF.md
# Endpoint FIFO Access Handshake Controller

This block lets a local processor move data into and out of a set of USB endpoint FIFOs through one 8-bit command and status register. Beside the register sits a byte-wide data port. The endpoint being worked on comes from a separate select input. Software raises a request, picks a direction and waits for the ready bit. It then moves bytes through the data port. It ends the transfer by flipping the direction bit while the request is still held.

The USB side of the block pushes received OUT bytes into a FIFO and pops IN bytes from it. It can also set the zero-length and SETUP flags. The controller paces every data-port access with a programmable cycle count, and the same count sets the delay from a new request to a valid ready bit. Software can empty one FIFO even when it is not ready. A host read of that endpoint that finds it empty afterwards produces a one-cycle forced transmit-error pulse.

Each endpoint has its own read and write pointers into one shared byte memory. The depth per endpoint is a parameter: 8 bytes by default, and it must be a power of two.

Top module: `ep_fifo_hs`

## Requirements
- R1: Register bits are: bit0 request, bit1 direction (1 = processor writes, 0 = processor reads), bit2 clear, bit3 serial-DMA enable, bit4 serial-DMA select, bit5 SETUP flag, bit6 ready, bit7 zero-length flag. Bits 0 to 5 read back as last written. Bit 6 is read-only and ignores writes.
- R2: Either the block reset or `usb_rst` makes the register read 00h and clears `access_err`.
- R3: After the register write that raises the request, bit 6 stays 0 for WAIT_CYC clock edges. If the FIFO condition holds, it reads 1 after the next edge. The same spacing of WAIT_CYC+1 edges applies after every data-port access.
- R4: With direction 0, ready means the selected FIFO holds data. Each accepted `dp_rd` returns the oldest byte on `dp_rdata` one edge later. Ready stays 0 once the FIFO is drained.
- R5: With direction 1, ready means the selected FIFO has space. Bytes are stored in order. Ready stays 0 once DEPTH bytes are held.
- R6: With the request held, a register write that flips direction 1 to 0 gives a one-cycle `xfer_end` with `xfer_write` = 1. A flip from 0 to 1 gives `xfer_end` with `xfer_write` = 0.
- R7: At the end of a write, `xfer_zlp` is 1 if no byte was accepted since the request rose, and 0 otherwise.
- R8: A register write that sets bit 2 while bit 0 stays set empties the selected FIFO, whether or not it was ready. The other endpoints keep their contents.
- R9: After a clear, the first `usb_rd` of that endpoint that finds it empty gives a one-cycle `force_tx_err`. A host read of an empty endpoint that was never cleared gives none.
- R10: A `dp_wr` or `dp_rd` while ready is 0 (including with no request) changes no FIFO and sets the sticky `access_err`.
- R11: `usb_zlp_set` sets bit 7. Writing 0 to bit 7 clears it. Writing 1 does not set it.
- R12: `usb_setup_set` sets bit 5. Bits 3 and 4 drive `sdma_en` and `sdma_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| usb_rst | input | 1 | USB bus reset, clears the register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register image |
| ep_sel | input | EPW | Endpoint chosen by software |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | DW | Data port write byte |
| dp_rd | input | 1 | Data port read strobe |
| dp_rdata | output | DW | Data port read byte, valid one edge after `dp_rd` |
| access_err | output | 1 | Sticky flag for refused data-port accesses |
| usb_ep | input | EPW | Endpoint addressed by the USB side |
| usb_wr | input | 1 | USB side pushes an OUT byte |
| usb_wdata | input | DW | OUT byte |
| usb_rd | input | 1 | USB side pops an IN byte |
| usb_rdata | output | DW | IN byte, valid one edge after `usb_rd` |
| usb_zlp_set | input | 1 | Host sent an empty OUT packet |
| usb_setup_set | input | 1 | SETUP token seen |
| force_tx_err | output | 1 | Underrun pulse after a cleared endpoint is read |
| xfer_end | output | 1 | End-of-transfer pulse |
| xfer_write | output | 1 | Ended transfer was a processor write |
| xfer_zlp | output | 1 | Ended write carried no bytes |
| sdma_en | output | 1 | Serial-DMA enable bit |
| sdma_sel | output | 1 | Serial-DMA interface select bit |

## Verification
The bench counts the latency edge by edge after a request and after every data access. A design that is off by one shows ready a cycle early or late. It fills one endpoint to exactly DEPTH and drains another byte by byte. A wrong full or empty boundary then leaves ready set past the limit or drops it early. An early refused write is followed by a full-depth fill. If that write had leaked into the FIFO, the last byte would be lost and the byte order seen from the USB side would shift. The bench clears one loaded endpoint with data waiting in a neighbour. A clear decoded against the wrong endpoint loses the neighbour's bytes. A missing underrun flag leaves no error pulse, and an error flag that never clears pulses on every empty read.

// File: rtl/ep_fifo_hs_pkg.sv
package ep_fifo_hs_pkg;
  // register image, MSB first
  typedef struct packed {
    logic zlp;
    logic ready;
    logic setup;
    logic dsel;
    logic den;
    logic clr;
    logic dir;
    logic req;
  } ctl_t;
endpackage

// File: rtl/ep_fifo_hs_pace.sv
module ep_fifo_hs_pace #(
  parameter int WAIT_CYC = 4,
  localparam int CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic idle
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CW'(WAIT_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // R3: a fresh load always opens a wait window
  p_load_opens_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (load && (WAIT_CYC > 0)) |=> !idle);
endmodule

// File: rtl/ep_fifo_hs_bank.sv
module ep_fifo_hs_bank #(
  parameter int NEP   = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int EPW  = $clog2(NEP),
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           a_push,
  input  logic           a_pop,
  input  logic [EPW-1:0] a_ep,
  input  logic [DW-1:0]  a_wdata,
  output logic [DW-1:0]  a_rdata,
  output logic           a_empty,
  output logic           a_full,
  input  logic           b_push,
  input  logic           b_pop,
  input  logic [EPW-1:0] b_ep,
  input  logic [DW-1:0]  b_wdata,
  output logic [DW-1:0]  b_rdata,
  output logic           b_empty,
  input  logic           clr,
  input  logic [EPW-1:0] clr_ep
);
  logic [DW-1:0] mem [NEP*DEPTH];
  logic [PW-1:0] wp [NEP];
  logic [PW-1:0] rp [NEP];
  logic [PW-1:0] a_occ, b_occ;
  logic          b_full;
  logic          a_push_ok, a_pop_ok, b_push_ok, b_pop_ok;

  assign a_occ   = wp[a_ep] - rp[a_ep];
  assign b_occ   = wp[b_ep] - rp[b_ep];
  assign a_empty = (a_occ == '0);
  assign a_full  = (a_occ == PW'(DEPTH));
  assign b_empty = (b_occ == '0);
  assign b_full  = (b_occ == PW'(DEPTH));

  assign a_push_ok = a_push && !a_full;
  assign a_pop_ok  = a_pop  && !a_empty;
  assign b_push_ok = b_push && !b_full;
  assign b_pop_ok  = b_pop  && !b_empty;

  // storage: two ports, no reset, so it maps to a dual-port RAM
  always_ff @(posedge clk) begin
    if (a_push_ok) mem[{a_ep, wp[a_ep][AW-1:0]}] <= a_wdata;
    if (b_push_ok) mem[{b_ep, wp[b_ep][AW-1:0]}] <= b_wdata;
    if (a_pop_ok)  a_rdata <= mem[{a_ep, rp[a_ep][AW-1:0]}];
    if (b_pop_ok)  b_rdata <= mem[{b_ep, rp[b_ep][AW-1:0]}];
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NEP; e++) begin
      if (rst || (clr && clr_ep == EPW'(e))) begin
        wp[e] <= '0;
        rp[e] <= '0;
      end else begin
        wp[e] <= wp[e] + PW'(a_push_ok && a_ep == EPW'(e))
                       + PW'(b_push_ok && b_ep == EPW'(e));
        rp[e] <= rp[e] + PW'(a_pop_ok && a_ep == EPW'(e))
                       + PW'(b_pop_ok && b_ep == EPW'(e));
      end
    end
  end

  for (genvar g = 0; g < NEP; g++) begin : g_ep_chk
    logic touched;
    assign touched = ((a_push || a_pop) && a_ep == EPW'(g)) ||
                     ((b_push || b_pop) && b_ep == EPW'(g));

    p_occ_bound_r5: assert property (@(posedge clk) disable iff (rst)
      (wp[g] - rp[g]) <= PW'(DEPTH));

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
      (clr && clr_ep == EPW'(g)) |=> (wp[g] == rp[g]));

    p_clear_isolated_r8: assert property (@(posedge clk) disable iff (rst)
      (clr && clr_ep != EPW'(g) && !touched) |=> ($stable(wp[g]) && $stable(rp[g])));
  end
endmodule

// File: rtl/ep_fifo_hs.sv
module ep_fifo_hs
  import ep_fifo_hs_pkg::*;
#(
  parameter int NEP      = 4,
  parameter int DEPTH    = 8,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 4,
  localparam int EPW     = $clog2(NEP)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           usb_rst,
  input  logic           reg_wr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic [EPW-1:0] ep_sel,
  input  logic           dp_wr,
  input  logic [DW-1:0]  dp_wdata,
  input  logic           dp_rd,
  output logic [DW-1:0]  dp_rdata,
  output logic           access_err,
  input  logic [EPW-1:0] usb_ep,
  input  logic           usb_wr,
  input  logic [DW-1:0]  usb_wdata,
  input  logic           usb_rd,
  output logic [DW-1:0]  usb_rdata,
  input  logic           usb_zlp_set,
  input  logic           usb_setup_set,
  output logic           force_tx_err,
  output logic           xfer_end,
  output logic           xfer_write,
  output logic           xfer_zlp,
  output logic           sdma_en,
  output logic           sdma_sel
);
  ctl_t           ctl;
  logic           any_wr;
  logic [NEP-1:0] uflag;
  logic           a_empty, a_full, b_empty, idle;
  logic           req_rise, dir_flip, end_wr, end_rd, clr_go;
  logic           mcu_push, mcu_pop, bad_acc, fifo_ok, tx_err_hit;

  assign req_rise = reg_wr && reg_wdata[0] && !ctl.req;
  assign dir_flip = reg_wr && reg_wdata[0] && ctl.req && (reg_wdata[1] != ctl.dir);
  assign end_wr   = dir_flip && ctl.dir;
  assign end_rd   = dir_flip && !ctl.dir;
  assign clr_go   = reg_wr && reg_wdata[0] && reg_wdata[2] && ctl.req && !ctl.clr;

  assign mcu_push = dp_wr && ctl.ready && ctl.dir;
  assign mcu_pop  = dp_rd && ctl.ready && !ctl.dir;
  assign bad_acc  = (dp_wr && !(ctl.ready && ctl.dir)) ||
                    (dp_rd && !(ctl.ready && !ctl.dir));
  assign fifo_ok  = ctl.dir ? !a_full : !a_empty;
  assign tx_err_hit = usb_rd && b_empty && uflag[usb_ep];

  ep_fifo_hs_pace #(.WAIT_CYC(WAIT_CYC)) u_pace (
    .clk  (clk),
    .rst  (rst),
    .load (req_rise || dir_flip || mcu_push || mcu_pop),
    .idle (idle)
  );

  ep_fifo_hs_bank #(.NEP(NEP), .DEPTH(DEPTH), .DW(DW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .a_push  (mcu_push),
    .a_pop   (mcu_pop),
    .a_ep    (ep_sel),
    .a_wdata (dp_wdata),
    .a_rdata (dp_rdata),
    .a_empty (a_empty),
    .a_full  (a_full),
    .b_push  (usb_wr),
    .b_pop   (usb_rd),
    .b_ep    (usb_ep),
    .b_wdata (usb_wdata),
    .b_rdata (usb_rdata),
    .b_empty (b_empty),
    .clr     (clr_go),
    .clr_ep  (ep_sel)
  );

  always_ff @(posedge clk) begin
    if (rst || usb_rst) begin
      ctl          <= '0;
      any_wr       <= 1'b0;
      access_err   <= 1'b0;
      force_tx_err <= 1'b0;
      xfer_end     <= 1'b0;
      xfer_write   <= 1'b0;
      xfer_zlp     <= 1'b0;
    end else begin
      if (reg_wr) begin
        ctl.req  <= reg_wdata[0];
        ctl.dir  <= reg_wdata[1];
        ctl.clr  <= reg_wdata[2];
        ctl.den  <= reg_wdata[3];
        ctl.dsel <= reg_wdata[4];
      end
      if (usb_setup_set)   ctl.setup <= 1'b1;
      else if (reg_wr)     ctl.setup <= reg_wdata[5];
      if (usb_zlp_set)                  ctl.zlp <= 1'b1;
      else if (reg_wr && !reg_wdata[7]) ctl.zlp <= 1'b0;

      if (reg_wr || mcu_push || mcu_pop) ctl.ready <= 1'b0;
      else ctl.ready <= ctl.req && !ctl.clr && idle && fifo_ok;

      if (req_rise)      any_wr <= 1'b0;
      else if (mcu_push) any_wr <= 1'b1;

      if (bad_acc) access_err <= 1'b1;

      xfer_end     <= end_wr || end_rd;
      xfer_write   <= end_wr;
      xfer_zlp     <= end_wr && !any_wr;
      force_tx_err <= tx_err_hit;
    end
  end

  // underrun memory per endpoint
  always_ff @(posedge clk) begin
    if (rst) uflag <= '0;
    else begin
      for (int e = 0; e < NEP; e++) begin
        if (clr_go && ep_sel == EPW'(e))
          uflag[e] <= 1'b1;
        else if ((mcu_push && ep_sel == EPW'(e)) || (tx_err_hit && usb_ep == EPW'(e)))
          uflag[e] <= 1'b0;
      end
    end
  end

  assign reg_rdata = ctl;
  assign sdma_en   = ctl.den;
  assign sdma_sel  = ctl.dsel;

  p_ready_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.ready |-> ctl.req);
  p_ready_after_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl.ready) |-> $past(idle));
  p_refused_flags_r10: assert property (@(posedge clk) disable iff (rst)
    ((dp_wr || dp_rd) && !ctl.ready && !usb_rst) |=> access_err);
  p_usb_reset_clears_r2: assert property (@(posedge clk) disable iff (rst)
    usb_rst |=> (reg_rdata == 8'h00));
  p_zlp_is_write_end_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_zlp |-> (xfer_end && xfer_write));
  p_end_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> ($past(reg_wr) && $past(ctl.req)));
  p_txerr_from_read_r9: assert property (@(posedge clk) disable iff (rst)
    force_tx_err |-> $past(usb_rd));
endmodule

// File: tb/ep_fifo_hs_test.sv
module ep_fifo_hs_test;
  localparam int NEP = 4, DEPTH = 8, DW = 8, W = 4, EPW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1, usb_rst = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [EPW-1:0] ep_sel = '0, usb_ep = '0;
  logic dp_wr = 1'b0, dp_rd = 1'b0, usb_wr = 1'b0, usb_rd = 1'b0;
  logic [DW-1:0] dp_wdata = '0, usb_wdata = '0, dp_rdata, usb_rdata;
  logic access_err, force_tx_err, xfer_end, xfer_write, xfer_zlp, sdma_en, sdma_sel;
  logic usb_zlp_set = 1'b0, usb_setup_set = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ep_fifo_hs #(.NEP(NEP), .DEPTH(DEPTH), .DW(DW), .WAIT_CYC(W)) uut (
    .clk(clk), .rst(rst), .usb_rst(usb_rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ep_sel(ep_sel), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .dp_rd(dp_rd), .dp_rdata(dp_rdata), .access_err(access_err), .usb_ep(usb_ep),
    .usb_wr(usb_wr), .usb_wdata(usb_wdata), .usb_rd(usb_rd), .usb_rdata(usb_rdata),
    .usb_zlp_set(usb_zlp_set), .usb_setup_set(usb_setup_set), .force_tx_err(force_tx_err),
    .xfer_end(xfer_end), .xfer_write(xfer_write), .xfer_zlp(xfer_zlp),
    .sdma_en(sdma_en), .sdma_sel(sdma_sel));

  function automatic logic [7:0] pat(input int ep, input int i);
    return 8'(ep * 37 + i * 11 + 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic regw(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v; tick(); reg_wr = 1'b0;
  endtask

  task automatic dpw(input logic [7:0] d);
    dp_wr = 1'b1; dp_wdata = d; tick(); dp_wr = 1'b0;
  endtask

  task automatic dpr();
    dp_rd = 1'b1; tick(); dp_rd = 1'b0;
  endtask

  task automatic upush(input int ep, input logic [7:0] d);
    usb_wr = 1'b1; usb_ep = EPW'(ep); usb_wdata = d; tick(); usb_wr = 1'b0;
  endtask

  task automatic upull(input int ep);
    usb_rd = 1'b1; usb_ep = EPW'(ep); tick(); usb_rd = 1'b0;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R2 reset register", reg_rdata, 8'h00);
    chk("R2 reset access_err", access_err, 0);
    chk("R9 reset force_tx_err", force_tx_err, 0);

    // R1 / R12: readback of writable bits, ready bit read-only
    regw(8'h3C);
    chk("R1 readback 3C", reg_rdata, 8'h3C);
    chk("R12 sdma_en", sdma_en, 1);
    chk("R12 sdma_sel", sdma_sel, 1);
    regw(8'h40);
    chk("R1 ready bit read-only", reg_rdata, 8'h00);

    // R11 zero-length flag
    usb_zlp_set = 1'b1; tick(); usb_zlp_set = 1'b0;
    chk("R11 zlp set by usb", reg_rdata, 8'h80);
    regw(8'h80);
    chk("R11 write 1 keeps", reg_rdata, 8'h80);
    regw(8'h00);
    chk("R11 write 0 clears", reg_rdata, 8'h00);
    usb_setup_set = 1'b1; tick(); usb_setup_set = 1'b0;
    chk("R12 setup flag set", reg_rdata, 8'h20);

    // R10: refused write with no request
    regw(8'h00);
    dpw(8'hEE);
    chk("R10 refused write flags", access_err, 1);
    regw(8'h3B);
    usb_rst = 1'b1; tick(); usb_rst = 1'b0;
    chk("R2 usb reset register", reg_rdata, 8'h00);
    chk("R2 usb reset access_err", access_err, 0);

    // R3 / R5: write sequence filling endpoint 0
    ep_sel = 2'd0;
    regw(8'h02); regw(8'h03);
    repeat (W) tick();
    chk("R3 not ready before latency", reg_rdata, 8'h03);
    tick();
    chk("R3 ready after latency", reg_rdata, 8'h43);
    for (int i = 0; i < DEPTH; i++) begin
      dpw(pat(0, i));
      chk("R3 ready drops after access", reg_rdata[6], 0);
      repeat (W) tick();
      chk("R3 spacing holds", reg_rdata[6], 0);
      tick();
      chk("R5 ready vs space", reg_rdata[6], (i < DEPTH - 1) ? 1 : 0);
    end
    chk("R10 no later error", access_err, 0);
    regw(8'h01);
    chk("R6 write end pulse", xfer_end, 1);
    chk("R6 write end dir", xfer_write, 1);
    chk("R7 non-empty write", xfer_zlp, 0);
    regw(8'h00);
    chk("R6 pulse one cycle", xfer_end, 0);

    // USB side drains endpoint 0: order proves refused write stayed out (R10)
    for (int i = 0; i < DEPTH; i++) begin
      upull(0);
      chk("R5 stored order", usb_rdata, pat(0, i));
    end
    upull(0);
    chk("R9 no error without clear", force_tx_err, 0);

    // R4: processor read of endpoint 1
    for (int i = 0; i < 5; i++) upush(1, pat(1, i));
    ep_sel = 2'd1;
    regw(8'h00); regw(8'h01);
    repeat (W) tick();
    chk("R3 read not ready early", reg_rdata, 8'h01);
    tick();
    chk("R4 ready with data", reg_rdata, 8'h41);
    for (int i = 0; i < 5; i++) begin
      dpr();
      chk("R4 read data", dp_rdata, pat(1, i));
      repeat (W + 1) tick();
      chk("R4 ready vs remaining", reg_rdata[6], (i < 4) ? 1 : 0);
    end
    regw(8'h03);
    chk("R6 read end pulse", xfer_end, 1);
    chk("R6 read end dir", xfer_write, 0);
    regw(8'h02);

    // R7: empty write on endpoint 2
    ep_sel = 2'd2;
    regw(8'h02); regw(8'h03);
    repeat (W + 1) tick();
    chk("R5 empty fifo ready", reg_rdata, 8'h43);
    regw(8'h01);
    chk("R7 zlp end pulse", xfer_end, 1);
    chk("R7 zlp flag", xfer_zlp, 1);
    regw(8'h00);

    // R8 / R9: clear endpoint 3 while endpoint 2 holds data
    for (int i = 0; i < 3; i++) upush(3, pat(3, i));
    for (int i = 0; i < 2; i++) upush(2, pat(2, i));
    ep_sel = 2'd3;
    regw(8'h01);
    repeat (W + 1) tick();
    chk("R4 ready before clear", reg_rdata, 8'h41);
    regw(8'h05);
    regw(8'h00);
    upull(3);
    chk("R9 underrun pulse", force_tx_err, 1);
    tick();
    chk("R9 pulse one cycle", force_tx_err, 0);
    upull(3);
    chk("R9 flag consumed", force_tx_err, 0);
    for (int i = 0; i < 2; i++) begin
      upull(2);
      chk("R8 other endpoint kept", usb_rdata, pat(2, i));
    end
    regw(8'h01);
    repeat (W + 1) tick();
    chk("R8 cleared fifo empty", reg_rdata, 8'h01);
    dpr();
    chk("R10 refused read flags", access_err, 1);
    regw(8'h00);

    report();
  end
endmodule